// File: doc/BRIEF.md
# NAND page read sequencer

This block opens a page read on a NAND flash device and then streams the page's bytes out to a consumer. It does the work through a bus timing controller's request interface. A single `start` pulse supplies three things: a 26-bit start address, a flag that picks a three-byte or a four-byte address phase, and a byte count. The sequencer first writes the read command byte to the command-latch region, but only if the device does not already hold that command. It then writes the address bytes to the address-latch region, lowest byte first, and waits for the device's ready line to go high. After that it reads the data bytes one bus transaction at a time.

Each byte read from the device is placed on a valid/ready byte stream and held there until the consumer takes it. The sequencer keeps a flag that records whether the read command is already latched in the device. Reset clears this flag, and so does a host invalidate pulse. The host can use invalidate after it has sent the device any other command. `busy` tells the host when a new page read may be started.

Top module: `nand_page_read_seq`

## Requirements
- R1: A `start` pulse seen while `busy` is low captures `startAddr`, `addrFour` and `readCount`, and `busy` is high from the next cycle. A `start` seen while `busy` is high is ignored and produces no bus request.
- R2: On the first page read after reset, the first bus request is a write of byte 0x00 to the command region (`busRegion` = 1).
- R3: Once a command write has been acknowledged, later page reads send no command write and begin directly with the address bytes.
- R4: A one-cycle `invalidate` pulse clears the latched-command state, so the next page read sends the 0x00 command write again.
- R5: Address bytes are writes to the address region (`busRegion` = 2), sent in order: bits 7:0, then 15:8, then 23:16, then a fourth byte {6'b0, bits 25:24}.
- R6: With `addrFour` = 0 exactly the first three address bytes are sent. With `addrFour` = 1 all four are sent.
- R7: While `busReq` is high and `busAck` is low, `busReq`, `busWrite`, `busRegion` and `busWdata` hold their values into the next cycle. A request completes in a cycle where `busReq` and `busAck` are both high.
- R8: After the last address byte is acknowledged, no data read request is issued until `devReady` has been seen high.
- R9: Data reads are requests with `busWrite` = 0 to the data region (`busRegion` = 0), exactly `readCount` of them. Each returned `busRdata` byte appears on `outData` with `outValid` high and stays stable until `outReady` is high.
- R10: `busy` goes low in the cycle after the last data byte is accepted. With `readCount` = 0 no data read is issued, and `busy` goes low once `devReady` is seen high after the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page read (taken only when idle) |
| startAddr | input | 26 | Page start address |
| addrFour | input | 1 | 1: four address bytes, 0: three |
| readCount | input | 12 | Number of data bytes to read |
| invalidate | input | 1 | Forget that the read command is latched |
| busReq | output | 1 | Bus transaction request |
| busWrite | output | 1 | 1: write, 0: read |
| busRegion | output | 2 | 0 data, 1 command latch, 2 address latch |
| busWdata | output | 8 | Write byte |
| busAck | input | 1 | Transaction accepted this cycle |
| busRdata | input | 8 | Read byte, valid with busAck on a read |
| devReady | input | 1 | Device ready (high = ready) |
| outValid | output | 1 | Stream byte valid |
| outData | output | 8 | Stream byte |
| outReady | input | 1 | Consumer accepts byte |
| busy | output | 1 | Page read in progress |

## Verification
The hardest case to reach is a data read issued too early. A design that skips the ready wait looks correct whenever the ready line happens to be high already. The bench therefore holds `devReady` low for a set number of cycles after each start, longer than the whole address phase even with slow acknowledgements. The bus responder then checks that every data read request arrives with ready already high. The skipped command is a second case that is easy to miss. It is only visible in the ordering of requests, so the scoreboard builds the expected request list from its own model of the latched flag, which invalidate clears. A spurious start is also injected in the middle of a job to show that it adds no requests.

// File: rtl/nprs_pkg.sv
`timescale 1ns/1ps
package nprs_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CMD  = 2'd1,
    REG_ADDR = 2'd2
  } region_e;

  localparam logic [7:0] READ_CMD = 8'h00;

  // strobes from control to datapath
  typedef struct packed {
    logic loadJob;
    logic incIdx;
    logic decCnt;
    logic capData;
    logic setLatched;
    logic selCmd;
  } dpCtl_t;
endpackage

// File: rtl/nprs_datapath.sv
`timescale 1ns/1ps
module nprs_datapath
  import nprs_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              addrFour,
  input  logic [CNT_W-1:0]  readCount,
  input  logic              invalidate,
  input  logic [7:0]        busRdata,
  output logic [7:0]        busWdata,
  output logic [7:0]        outData,
  output logic              idxLast,
  output logic              cntZero,
  output logic              cntOne,
  output logic              latched
);
  localparam int PAD_W = 32;

  logic [ADDR_W-1:0] addrReg;
  logic              fourReg;
  logic [1:0]        idx;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        dataReg;
  logic              latchedReg;
  logic [PAD_W-1:0]  padded;
  logic [7:0]        addrByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      fourReg <= 1'b0;
      idx     <= '0;
      cnt     <= '0;
      dataReg <= '0;
    end else begin
      if (ctl.loadJob) begin
        addrReg <= startAddr;
        fourReg <= addrFour;
        idx     <= '0;
        cnt     <= readCount;
      end else begin
        if (ctl.incIdx) idx <= idx + 2'd1;
        if (ctl.decCnt) cnt <= cnt - 1'b1;
      end
      if (ctl.capData) dataReg <= busRdata;
    end
  end

  // command-latched memory; invalidate wins over a same-cycle set
  always_ff @(posedge clk) begin
    if (!rstN)               latchedReg <= 1'b0;
    else if (invalidate)     latchedReg <= 1'b0;
    else if (ctl.setLatched) latchedReg <= 1'b1;
  end

  assign padded   = PAD_W'(addrReg);
  assign addrByte = padded[{idx, 3'b000} +: 8];
  assign busWdata = ctl.selCmd ? READ_CMD : addrByte;
  assign outData  = dataReg;
  assign idxLast  = fourReg ? (idx == 2'd3) : (idx == 2'd2);
  assign cntZero  = (cnt == '0);
  assign cntOne   = (cnt == CNT_W'(1));
  assign latched  = latchedReg;
endmodule

// File: rtl/nprs_control.sv
`timescale 1ns/1ps
module nprs_control
  import nprs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busAck,
  input  logic       devReady,
  input  logic       outReady,
  input  logic       idxLast,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       latched,
  output dpCtl_t     ctl,
  output logic       busReq,
  output logic       busWrite,
  output logic [1:0] busRegion,
  output logic       outValid,
  output logic       busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_WAIT, S_READ, S_PUSH
  } state_e;

  state_e state, nextState;
  region_e region;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    busReq    = 1'b0;
    busWrite  = 1'b0;
    region    = REG_DATA;
    outValid  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadJob = 1'b1;
          nextState   = latched ? S_ADDR : S_CMD;
        end
      end
      S_CMD: begin
        busReq     = 1'b1;
        busWrite   = 1'b1;
        region     = REG_CMD;
        ctl.selCmd = 1'b1;
        if (busAck) begin
          ctl.setLatched = 1'b1;
          nextState      = S_ADDR;
        end
      end
      S_ADDR: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        region   = REG_ADDR;
        if (busAck) begin
          if (idxLast) nextState  = S_WAIT;
          else         ctl.incIdx = 1'b1;
        end
      end
      S_WAIT: begin
        if (devReady) nextState = cntZero ? S_IDLE : S_READ;
      end
      S_READ: begin
        busReq = 1'b1;
        region = REG_DATA;
        if (busAck) begin
          ctl.capData = 1'b1;
          nextState   = S_PUSH;
        end
      end
      S_PUSH: begin
        outValid = 1'b1;
        if (outReady) begin
          ctl.decCnt = 1'b1;
          nextState  = cntOne ? S_IDLE : S_READ;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busRegion = region;
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/nand_page_read_seq.sv
`timescale 1ns/1ps
module nand_page_read_seq
  import nprs_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              addrFour,
  input  logic [CNT_W-1:0]  readCount,
  input  logic              invalidate,
  output logic              busReq,
  output logic              busWrite,
  output logic [1:0]        busRegion,
  output logic [7:0]        busWdata,
  input  logic              busAck,
  input  logic [7:0]        busRdata,
  input  logic              devReady,
  output logic              outValid,
  output logic [7:0]        outData,
  input  logic              outReady,
  output logic              busy
);
  dpCtl_t ctl;
  logic   idxLast, cntZero, cntOne, latched;

  nprs_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busAck(busAck),
    .devReady(devReady), .outReady(outReady), .idxLast(idxLast),
    .cntZero(cntZero), .cntOne(cntOne), .latched(latched),
    .ctl(ctl), .busReq(busReq), .busWrite(busWrite),
    .busRegion(busRegion), .outValid(outValid), .busy(busy)
  );

  nprs_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .addrFour(addrFour), .readCount(readCount), .invalidate(invalidate),
    .busRdata(busRdata), .busWdata(busWdata), .outData(outData),
    .idxLast(idxLast), .cntZero(cntZero), .cntOne(cntOne),
    .latched(latched)
  );
endmodule

// File: rtl/nprs_checker.sv
`timescale 1ns/1ps
module nprs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       busReq,
  input logic       busAck,
  input logic       busWrite,
  input logic [1:0] busRegion,
  input logic [7:0] busWdata,
  input logic       devReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData
);
  // ready seen since the most recent address-byte completion
  logic sawReady;
  always_ff @(posedge clk) begin
    if (!rstN) sawReady <= 1'b0;
    else if (busReq && busAck && busRegion == 2'd2) sawReady <= 1'b0;
    else if (devReady) sawReady <= 1'b1;
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_cmd_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busRegion == 2'd1) |-> (busWrite && busWdata == 8'h00));

  p_addr_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busRegion == 2'd2) |-> busWrite);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busWrite) &&
                             $stable(busRegion) && $stable(busWdata)));

  p_ready_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite) |-> sawReady);

  p_read_region_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite) |-> (busRegion == 2'd0));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busReq && !outValid));
endmodule

bind nand_page_read_seq nprs_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .busReq(busReq),
  .busAck(busAck), .busWrite(busWrite), .busRegion(busRegion),
  .busWdata(busWdata), .devReady(devReady), .outValid(outValid),
  .outReady(outReady), .outData(outData)
);

// File: tb/nand_page_read_seq_tb.sv
`timescale 1ns/1ps
module nand_page_read_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [25:0] startAddr = '0;
  logic        addrFour = 1'b0;
  logic [11:0] readCount = '0;
  logic        invalidate = 1'b0;
  logic        busReq, busWrite;
  logic [1:0]  busRegion;
  logic [7:0]  busWdata;
  logic        busAck = 1'b0;
  logic [7:0]  busRdata = '0;
  logic        devReady;
  logic        outValid;
  logic [7:0]  outData;
  logic        outReady = 1'b1;
  logic        busy;

  always #2.5 clk = ~clk;

  nand_page_read_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .addrFour(addrFour), .readCount(readCount), .invalidate(invalidate),
    .busReq(busReq), .busWrite(busWrite), .busRegion(busRegion),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata),
    .devReady(devReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .busy(busy)
  );

  typedef struct {
    logic       wr;
    logic [1:0] rg;
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t       busQ[$];
  logic [7:0] outQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int cyc = 0;
  int readyAt = 0;
  int ackDelay = 0;
  bit stallOut = 0;
  bit mdlLatched = 0;
  int drvSeq = 0;

  assign devReady = (cyc >= readyAt);
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // bus responder and request scoreboard
  bit inFlight = 0;
  int wcnt = 0;
  int rdSeq = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      busAck = 1'b0;
      inFlight = 0;
    end else begin
      if (busAck) begin
        busAck = 1'b0;
        inFlight = 0;
      end
      if (busReq && !inFlight) begin
        inFlight = 1;
        wcnt = 0;
        if (busQ.size() == 0) begin
          check(0, "R1", "unexpected request", {busWrite, busRegion}, 0);
        end else begin
          exp_t e;
          e = busQ.pop_front();
          check({busWrite, busRegion, (busWrite ? busWdata : 8'h00)} ==
                {e.wr, e.rg, e.d}, e.tag, "request {wr,region,data}",
                {busWrite, busRegion, (busWrite ? busWdata : 8'h00)},
                {e.wr, e.rg, e.d});
          if (!busWrite)
            check(devReady === 1'b1, "R8", "read before ready", devReady, 1);
        end
      end
      if (busReq && inFlight && !busAck) begin
        if (wcnt >= ackDelay) begin
          busAck = 1'b1;
          if (!busWrite) begin
            busRdata = 8'(8'h35 + rdSeq * 11);
            rdSeq++;
          end
        end else wcnt++;
      end
    end
  end

  // stream consumer
  always @(negedge clk) begin
    outReady = stallOut ? (cyc % 3 == 0) : 1'b1;
    if (rstN && outValid && outReady) begin
      if (outQ.size() == 0) check(0, "R9", "unexpected byte", outData, 0);
      else begin
        logic [7:0] x;
        x = outQ.pop_front();
        check(outData == x, "R9", "stream byte", outData, x);
      end
    end
  end

  task automatic runJob(input logic [25:0] a, input bit four, input int cnt,
                        input string cmdTag, input int readyDelay, input bit spur);
    exp_t e;
    int nb;
    if (!mdlLatched) begin
      e.wr = 1; e.rg = 2'd1; e.d = 8'h00; e.tag = cmdTag;
      busQ.push_back(e);
    end
    mdlLatched = 1;
    nb = four ? 4 : 3;
    for (int i = 0; i < nb; i++) begin
      e.wr = 1; e.rg = 2'd2;
      e.d = (i == 3) ? {6'b0, a[25:24]} : a[8*i +: 8];
      e.tag = (i == 0) ? "R3/R5" : (four ? "R5" : "R6");
      busQ.push_back(e);
    end
    for (int k = 0; k < cnt; k++) begin
      e.wr = 0; e.rg = 2'd0; e.d = 8'h00; e.tag = "R9";
      busQ.push_back(e);
      outQ.push_back(8'(8'h35 + drvSeq * 11));
      drvSeq++;
    end
    @(negedge clk);
    startAddr = a; addrFour = four; readCount = 12'(cnt); start = 1'b1;
    readyAt = cyc + readyDelay;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    for (int g = 0; busy && g < 5000; g++) begin
      @(negedge clk);
      if (spur && g == 4) begin
        start = 1'b1; startAddr = ~a; readCount = 12'd7;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(busQ.size() == 0 && outQ.size() == 0, "R10", "items left at idle",
          busQ.size() + outQ.size(), 0);
    repeat (3) @(negedge clk);
    check(!busy && !busReq, "R1", "stays idle after job", {busy, busReq}, 0);
  endtask

  initial begin
    #750000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !busReq && !outValid, "R1", "reset state",
          {busy, busReq, outValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    ackDelay = 0; stallOut = 0;
    runJob(26'h2A5C3F1, 1'b1, 3, "R2", 20, 0);   // first read: command sent

    ackDelay = 2; stallOut = 1;
    runJob(26'h1234567, 1'b0, 2, "R3", 25, 0);   // latched: no command

    @(negedge clk) invalidate = 1'b1;
    @(negedge clk) invalidate = 1'b0;
    mdlLatched = 0;
    ackDelay = 1; stallOut = 0;
    runJob(26'h3FFFFFF, 1'b1, 1, "R4", 30, 0);   // command again after invalidate

    runJob(26'h00ABCDE, 1'b0, 0, "R2", 22, 0);   // zero count (R10)

    ackDelay = 0; stallOut = 1;
    runJob(26'h0F0F0F0, 1'b1, 4, "R2", 20, 1);   // spurious start while busy (R1)

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule